// File: doc/BRIEF.md
# Three-Channel Edge Timestamp Capture

This block records when signal transitions occur on three external input pins. Each channel watches its own pin. When the pin makes a transition of the kind selected for that channel, the channel takes a snapshot of one of two free-running 16-bit timer values and stores it in a small queue that holds two entries. A two-bit occupancy code tells software how many results are waiting and whether one was overwritten. A sticky per-channel event flag marks that a capture occurred.

Software removes results oldest-first through a per-channel read strobe, and can empty every queue at once with a single clear command. The third channel can also emit a one-cycle trigger to start an analog-to-digital conversion each time it captures. Pins are asynchronous to the block clock and are synchronized internally. The timers live outside the block and arrive here as plain value inputs.

Top module: `edge_capture_unit`

## Requirements
- R1: A pin level that is first sampled at rising clock edge E0 is captured at edge E0+2. The occupancy code does not change before that edge.
- R2: Each channel has a 2-bit edge mode (bits 2i+1:2i of `edge_mode` for channel i): 00 captures nothing, 01 captures rising transitions, 10 captures falling transitions, 11 captures both. Transitions that are not selected leave the queue unchanged.
- R3: When `tmr_sel` is 1, a capture stores `tmr1_val`. When it is 0, a capture stores `tmr2_val`.
- R4: The occupancy code of channel i is `fifo_status[2i+1:2i]`, with 00 for empty, 01 for one entry and 10 for two entries. Each capture raises the code by one step, and it never jumps from 00 to 10 or 11 in a single cycle.
- R5: A capture into a full queue sets the code to 11, drops the oldest entry and keeps the two newest values.
- R6: A read strobe on a non-empty queue removes the oldest entry: 01 becomes 00, and both 10 and 11 become 01. A read strobe on an empty queue has no effect.
- R7: `rd_data[16i+15:16i]` shows the oldest entry of channel i and is zero while that queue is empty.
- R8: When a capture and a read happen in the same cycle, the read is applied first and then the capture.
- R9: A pulse on `clr_fifos` sets every occupancy code to 00 at the next edge. It takes priority over a capture or a read in the same cycle, and that capture is dropped.
- R10: `cap_flag[i]` sets on every capture of channel i and stays set until `flag_clr[i]` is pulsed. If a set and a clear arrive in the same cycle, the set wins. The flag also sets when `clr_fifos` drops the value.
- R11: While `adc_trig_en` is 1, each capture of the third channel produces a single-cycle high on `adc_start`. While it is 0, `adc_start` stays low.
- R12: Reset empties all queues, clears all flags and holds `adc_start` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_pin | input | 3 | Asynchronous capture input pins, one per channel |
| edge_mode | input | 6 | Two-bit edge selection per channel |
| tmr_sel | input | 1 | Timer source select (1: timer 1, 0: timer 2) |
| tmr1_val | input | 16 | Current value of timer 1 |
| tmr2_val | input | 16 | Current value of timer 2 |
| rd_en | input | 3 | Per-channel read strobe, removes the oldest entry |
| clr_fifos | input | 1 | Empties all queues |
| flag_clr | input | 3 | Per-channel event flag clear |
| adc_trig_en | input | 1 | Enables the conversion trigger from the third channel |
| rd_data | output | 48 | Oldest entry of each channel, zero when empty |
| fifo_status | output | 6 | Two-bit occupancy code per channel |
| cap_flag | output | 3 | Sticky per-channel capture flags |
| adc_start | output | 1 | Single-cycle conversion trigger |

## Verification
The bound checker watches several rules on every cycle:
- the clear empties every queue;
- an empty queue never jumps straight to two entries or to overwritten;
- an empty queue reads zero;
- a read of an overwritten queue lands on one or two entries;
- a fresh first entry always comes with its flag;
- a conversion trigger only follows an enabled cycle.

Some properties depend on whole sequences, and only the bench scenarios can show them:
- which value survives an overwrite;
- the exact two-edge capture latency;
- the per-mode edge filtering;
- the timer choice;
- read-then-capture ordering in one cycle;
- the collision of a clear with a capture.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b10,
    ST_LOST  = 2'b11
  } fifo_st_e;

endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);
  import cap_pkg::*;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;
  logic              level, rise, fall;
  edge_mode_e        mode_e;

  // next state: shift the pin through the synchronizer, remember last level
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise   = level & ~last_q;
  assign fall   = ~level & last_q;
  assign mode_e = edge_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cap_fifo2.sv
module cap_fifo2 #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [TW-1:0] din,
  output logic [TW-1:0] head,
  output logic [1:0]    status
);
  import cap_pkg::*;

  logic [TW-1:0] ent0_q, ent0_d, ent1_q, ent1_d;
  fifo_st_e      st_q, st_d;
  logic          upd;

  // next state: clear wins; otherwise read first, then capture
  always_comb begin
    ent0_d = ent0_q;
    ent1_d = ent1_q;
    st_d   = st_q;
    if (clr) begin
      st_d = ST_EMPTY;
    end else begin
      if (pop && (st_q != ST_EMPTY)) begin
        ent0_d = ent1_q;
        st_d   = (st_q == ST_ONE) ? ST_EMPTY : ST_ONE;
      end
      if (push) begin
        unique case (st_d)
          ST_EMPTY: begin
            ent0_d = din;
            st_d   = ST_ONE;
          end
          ST_ONE: begin
            ent1_d = din;
            st_d   = ST_TWO;
          end
          default: begin
            ent0_d = ent1_q;
            ent1_d = din;
            st_d   = ST_LOST;
          end
        endcase
      end
    end
  end

  assign upd = clr | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent0_q <= '0;
      ent1_q <= '0;
      st_q   <= ST_EMPTY;
    end else if (upd) begin
      ent0_q <= ent0_d;
      ent1_q <= ent1_d;
      st_q   <= st_d;
    end
  end

  assign head   = (st_q == ST_EMPTY) ? '0 : ent0_q;
  assign status = st_q;

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int N_UNITS     = 3,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_UNITS-1:0]    cap_pin,
  input  logic [2*N_UNITS-1:0]  edge_mode,
  input  logic                  tmr_sel,
  input  logic [TW-1:0]         tmr1_val,
  input  logic [TW-1:0]         tmr2_val,
  input  logic [N_UNITS-1:0]    rd_en,
  input  logic                  clr_fifos,
  input  logic [N_UNITS-1:0]    flag_clr,
  input  logic                  adc_trig_en,
  output logic [TW*N_UNITS-1:0] rd_data,
  output logic [2*N_UNITS-1:0]  fifo_status,
  output logic [N_UNITS-1:0]    cap_flag,
  output logic                  adc_start
);

  localparam int ADC_UNIT = N_UNITS - 1;

  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic [TW-1:0]      cap_val;
  logic [N_UNITS-1:0] hit;
  logic [N_UNITS-1:0] flag_q, flag_d;
  logic               adc_q, adc_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign cap_val = tmr_sel ? tmr1_val : tmr2_val;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    cap_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk   (clk),
      .rst_n (rst_n_int),
      .pin   (cap_pin[i]),
      .mode  (edge_mode[2*i +: 2]),
      .hit   (hit[i])
    );

    cap_fifo2 #(.TW(TW)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .clr    (clr_fifos),
      .push   (hit[i]),
      .pop    (rd_en[i]),
      .din    (cap_val),
      .head   (rd_data[TW*i +: TW]),
      .status (fifo_status[2*i +: 2])
    );
  end

  // next state: flag set wins over clear; trigger follows the last channel
  always_comb begin
    flag_d = hit | (flag_q & ~flag_clr);
    adc_d  = adc_trig_en & hit[ADC_UNIT];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      flag_q <= '0;
      adc_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      adc_q  <= adc_d;
    end
  end

  assign cap_flag  = flag_q;
  assign adc_start = adc_q;

endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
  parameter int N_UNITS = 3,
  parameter int TW      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_UNITS-1:0]    rd_en,
  input logic                  clr_fifos,
  input logic                  adc_trig_en,
  input logic [TW*N_UNITS-1:0] rd_data,
  input logic [2*N_UNITS-1:0]  fifo_status,
  input logic [N_UNITS-1:0]    cap_flag,
  input logic                  adc_start
);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_chk
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fifos |=> (fifo_status[2*i +: 2] == 2'b00)); // R9

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_status[2*i +: 2] == 2'b00) |=> (fifo_status[2*i +: 2] inside {2'b00, 2'b01})); // R4

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_status[2*i +: 2] == 2'b00) |-> (rd_data[TW*i +: TW] == '0)); // R7

    AST_POP_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_status[2*i +: 2] == 2'b11 && rd_en[i] && !clr_fifos)
        |=> (fifo_status[2*i +: 2] inside {2'b01, 2'b10})); // R6

    AST_FIRST_ENTRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_status[2*i +: 2] == 2'b01 && $past(fifo_status[2*i +: 2]) == 2'b00
        && !$past(clr_fifos)) |-> cap_flag[i]); // R10
  end

  AST_ADC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(adc_trig_en) && cap_flag[N_UNITS-1])); // R11

endmodule

bind edge_capture_unit edge_capture_unit_chk #(.N_UNITS(N_UNITS), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .clr_fifos   (clr_fifos),
  .adc_trig_en (adc_trig_en),
  .rd_data     (rd_data),
  .fifo_status (fifo_status),
  .cap_flag    (cap_flag),
  .adc_start   (adc_start)
);

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cap_pin;
  logic [5:0]  edge_mode;
  logic        tmr_sel;
  logic [15:0] tmr1_val, tmr2_val;
  logic [2:0]  rd_en;
  logic        clr_fifos;
  logic [2:0]  flag_clr;
  logic        adc_trig_en;
  logic [47:0] rd_data;
  logic [5:0]  fifo_status;
  logic [2:0]  cap_flag;
  logic        adc_start;

  int n_chk  = 0;
  int n_fail = 0;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_mode(edge_mode),
    .tmr_sel(tmr_sel), .tmr1_val(tmr1_val), .tmr2_val(tmr2_val),
    .rd_en(rd_en), .clr_fifos(clr_fifos), .flag_clr(flag_clr),
    .adc_trig_en(adc_trig_en), .rd_data(rd_data), .fifo_status(fifo_status),
    .cap_flag(cap_flag), .adc_start(adc_start)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  pins;
    logic [15:0] t1;
    logic [5:0]  st;
    logic [15:0] h0;
    logic [15:0] h1;
    logic [15:0] h2;
  } vec_t;

  // modes: ch0 rising, ch1 falling, ch2 both; status is {ch2,ch1,ch0}
  localparam vec_t VECS [5] = '{
    '{3'b001, 16'h0100, 6'b000001, 16'h0100, 16'h0000, 16'h0000}, // R2 rise on ch0
    '{3'b111, 16'h0200, 6'b010001, 16'h0100, 16'h0000, 16'h0200}, // R2 ch1 rise ignored
    '{3'b010, 16'h0300, 6'b100001, 16'h0100, 16'h0000, 16'h0200}, // R2 ch0 fall ignored
    '{3'b000, 16'h0400, 6'b100101, 16'h0100, 16'h0400, 16'h0200}, // R4 ch1 fall
    '{3'b101, 16'h0500, 6'b110110, 16'h0100, 16'h0400, 16'h0300}  // R5 ch2 overwrite
  };

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(input int u);
    rd_en[u] = 1'b1;
    wait_neg(1);
    rd_en = '0;
  endtask

  task automatic count_adc(input int cycles, output int pulses);
    pulses = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (adc_start) pulses++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int pulses;
    rst_n = 1'b0; cap_pin = '0; edge_mode = 6'b11_10_01; tmr_sel = 1'b1;
    tmr1_val = '0; tmr2_val = '0; rd_en = '0; clr_fifos = 1'b0; flag_clr = '0;
    adc_trig_en = 1'b1;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);
    check("R12 reset status", fifo_status, 6'b0);
    check("R12 reset flags", cap_flag, 3'b0);
    check("R12 reset adc", adc_start, 1'b0);
    check("R7 empty reads zero", rd_data, 48'h0);

    // vector table
    for (int v = 0; v < 5; v++) begin
      cap_pin  = VECS[v].pins;
      tmr1_val = VECS[v].t1;
      wait_neg(5);
      check("R4 R5 status", fifo_status, VECS[v].st);
      check("R3 R7 head ch0", rd_data[15:0], VECS[v].h0);
      check("R7 head ch1", rd_data[31:16], VECS[v].h1);
      check("R5 head ch2", rd_data[47:32], VECS[v].h2);
    end
    check("R10 flags after table", cap_flag, 3'b111);

    // R6 reads
    pop(2);
    check("R6 pop overwritten ch2", fifo_status[5:4], 2'b01);
    check("R5 newest kept ch2", rd_data[47:32], 16'h0500);
    pop(0);
    check("R6 pop two ch0", fifo_status[1:0], 2'b01);
    check("R6 head after pop ch0", rd_data[15:0], 16'h0500);
    pop(0);
    check("R6 pop one ch0", fifo_status[1:0], 2'b00);
    check("R7 zero after drain", rd_data[15:0], 16'h0000);
    pop(0);
    check("R6 pop empty no effect", fifo_status[1:0], 2'b00);

    // R10 flag clear
    flag_clr = 3'b111;
    wait_neg(1);
    flag_clr = '0;
    check("R10 flags cleared", cap_flag, 3'b000);

    // R3 timer 2 selection on ch1
    tmr_sel = 1'b0; tmr2_val = 16'hABCD; tmr1_val = 16'h1111;
    cap_pin = 3'b111;
    wait_neg(5);
    cap_pin = 3'b101;
    wait_neg(5);
    check("R4 ch1 two entries", fifo_status[3:2], 2'b10);
    pop(1);
    check("R3 timer2 value", rd_data[31:16], 16'hABCD);
    tmr_sel = 1'b1;

    // R2 mode off
    edge_mode[1:0] = 2'b00;
    cap_pin = 3'b100;
    wait_neg(5);
    cap_pin = 3'b101;
    wait_neg(5);
    check("R2 mode off ignores both edges", fifo_status[1:0], 2'b00);
    edge_mode[1:0] = 2'b01;

    // R11 conversion trigger
    cap_pin = 3'b001;
    count_adc(8, pulses);
    check("R11 one pulse when enabled", pulses, 1);
    adc_trig_en = 1'b0;
    cap_pin = 3'b101;
    count_adc(8, pulses);
    check("R11 no pulse when disabled", pulses, 0);

    // R9 clear all
    clr_fifos = 1'b1;
    wait_neg(1);
    clr_fifos = 1'b0;
    check("R9 clear empties all", fifo_status, 6'b0);

    // R9 clear collides with capture on ch0
    cap_pin[0] = 1'b0;
    wait_neg(5);
    flag_clr = 3'b111;
    wait_neg(1);
    flag_clr = '0;
    cap_pin[0] = 1'b1;
    wait_neg(2);
    clr_fifos = 1'b1;
    wait_neg(1);
    clr_fifos = 1'b0;
    check("R9 clear beats capture", fifo_status[1:0], 2'b00);
    check("R10 flag set despite clear", cap_flag[0], 1'b1);

    // R1 latency
    cap_pin[0] = 1'b0;
    wait_neg(5);
    tmr1_val = 16'h7001;
    cap_pin[0] = 1'b1;
    wait_neg(2);
    check("R1 not yet captured", fifo_status[1:0], 2'b00);
    wait_neg(1);
    check("R1 captured at third edge", fifo_status[1:0], 2'b01);
    check("R1 value", rd_data[15:0], 16'h7001);

    // R8 capture and read in one cycle, R10 set wins over clear
    cap_pin[0] = 1'b0;
    wait_neg(5);
    tmr1_val = 16'h7002;
    cap_pin[0] = 1'b1;
    wait_neg(2);
    rd_en[0] = 1'b1;
    flag_clr[0] = 1'b1;
    wait_neg(1);
    rd_en = '0;
    flag_clr = '0;
    check("R8 read then capture status", fifo_status[1:0], 2'b01);
    check("R8 read then capture head", rd_data[15:0], 16'h7002);
    check("R10 set wins over clear", cap_flag[0], 1'b1);

    // R12 reset mid-run
    rst_n = 1'b0;
    wait_neg(1);
    check("R12 reset clears status", fifo_status, 6'b0);
    check("R12 reset clears flags", cap_flag, 3'b0);
    rst_n = 1'b1;
    wait_neg(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule